// File: doc/BRIEF.md
# I2C Byte-Level Master Controller

This block is a bus master for I2C that moves one bus event at a time under the control of software or a sequencer. An event is a start condition, one transmitted or received byte with its acknowledge bit, or a stop condition. When an event finishes, the block sets a completion flag. It also publishes an 8-bit status code that names the bus state just reached. The controlling agent reads that code, loads the data register if needed, and rewrites the control register to request the next event.

The two bus lines are open-drain. For each line the block provides an output-enable that pulls the wire low when high, and it reads the resolved wire back on a separate input. While the completion flag is set during a transfer, the block holds SCL low, so the bus waits for the controlling agent. The block detects loss of arbitration on any transmitted bit that it leaves released.

The block has four word registers, selected by `reg_addr`:

| `reg_addr` | Read | Write |
|---|---|---|
| 0 | data | data |
| 1 | control | control |
| 2 | status | timing factors |
| 3 | — | soft reset |

Control bits:

| Bit | Meaning |
|---|---|
| 2 | acknowledge-enable |
| 3 | completion flag (FLAG) |
| 4 | stop request |
| 5 | start request |
| 6 | enable |
| 7 | interrupt-enable |

Start and stop requests act once and read back as 0.

The timing register holds M in bits 6:3 and N in bits 2:0. Each bit on the bus takes four equal phases of (M+1)·2^N clock cycles. SCL is released for two of those phases. The phase that begins with SCL released does not finish while SCL still reads low.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, status reads 0xF8, FLAG (control bit 3) reads 0, `irq` is 0, and neither line is pulled.
- R2: A control write with enable (bit 6) and start (bit 5), made while no transfer is open, produces a start condition. It then sets FLAG and status 0x08 and leaves SCL pulled low.
- R3: The first byte after a start or repeated start is sent MSB first from the data register. Its bit 0 selects read (1) or write (0). The resulting status is 0x18 or 0x20 for a write address with ACK or NACK, and 0x40 or 0x48 for a read address with ACK or NACK.
- R4: In write mode, a control write with enable and neither start nor stop sends the data register. The resulting status is 0x28 on ACK and 0x30 on NACK.
- R5: In read mode, the same request receives a byte into the data register. The block returns ACK when control bit 2 is set, giving status 0x50. It returns NACK when bit 2 is clear, giving status 0x58.
- R6: A start request made while a transfer is open produces a repeated start with status 0x10.
- R7: A stop request made during a transfer drives a stop condition and releases both lines. It leaves status at 0xF8 and FLAG at 0.
- R8: A first address byte of the form 11110xxb that is acknowledged makes the next byte a second address byte. That byte reports 0xD0 or 0xD8 (write) or 0xE0 or 0xE8 (read) for ACK or NACK. In read mode, later bytes are received.
- R9: If SDA reads low during a transmitted bit that the block leaves released, the block releases both lines, ends the transfer and sets FLAG with status 0x38. A following start is a fresh start (0x08).
- R10: `irq` is high exactly when FLAG and interrupt-enable (bit 7) are both set.
- R11: FLAG stays set and SCL stays pulled low until a control write with bit 3 clear arrives. A control write with bit 3 set changes neither FLAG nor status.
- R12: SCL is released for 2·(M+1)·2^N cycles per bit, which is 18·(M+1)·2^N cycles per byte event.
- R13: A write to the soft-reset register releases both lines, clears FLAG, sets status to 0xF8 and closes any open transfer.
- R14: A control write without enable starts nothing. A byte request made while no transfer is open starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Resolved SCL level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Resolved SDA level |

## Verification
The bench attaches a behavioural slave with a 7-bit and a 10-bit address. It then walks several sequences:
- write with ACK and with NACK;
- a read that acknowledges one byte and refuses the next;
- a 10-bit address whose second byte is refused and then accepted in both directions;
- arbitration stolen by holding SDA low.

Each sequence catches a specific class of error:
- A design that reports 0x10 for the first start after an arbitration loss or a soft reset has left the transfer open.
- A design that moves on after a control write with bit 3 set ignores the hold rule.
- A design that returns ACK with bit 2 clear would leave the slave driving data after the last read.
- SCL-released time is counted for two timing settings, so a wrong period formula or an off-by-one phase gives a different count.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int MW = 4,
  parameter int NW = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  input  logic       scl_in,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int CW = MW + (1 << NW);
  localparam logic [7:0] ST_START = 8'h08, ST_RSTART = 8'h10, ST_ARB = 8'h38, ST_NONE = 8'hF8;

  typedef enum logic [1:0] {E_IDLE, E_START, E_BIT, E_STOP} eng_t;
  typedef enum logic [1:0] {K_A1, K_A2, K_WR, K_RD} kind_t;

  eng_t          eng;
  kind_t         kind, nk;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [CW-1:0] cnt, period_m1;
  logic [MW-1:0] m_r;
  logic [NW-1:0] n_r;
  logic [7:0]    data_r, sh, status;
  logic iflg, ack_en, en, ie, in_xfer, after_start, need_a2, rw, tcand, got_ack;

  assign period_m1 = ((CW'(m_r) + CW'(1)) << n_r) - CW'(1);

  wire ctrl_wr  = reg_wr && reg_addr == 2'd1;
  wire can_go   = ctrl_wr && eng == E_IDLE && reg_wdata[6] && !reg_wdata[3] && (iflg || !in_xfer);
  wire go_start = can_go && reg_wdata[5];
  wire go_stop  = can_go && !reg_wdata[5] && reg_wdata[4] && in_xfer;
  wire go_byte  = can_go && !reg_wdata[5] && !reg_wdata[4] && in_xfer;
  wire tick     = eng != E_IDLE && cnt == '0 && !(ph == 2'd2 && !scl_in);

  assign irq = iflg && ie;

  always_comb begin
    if (after_start)  nk = K_A1;
    else if (need_a2) nk = K_A2;
    else if (rw)      nk = K_RD;
    else              nk = K_WR;
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = data_r;
      2'd1:    reg_rdata = {ie, en, 2'b00, iflg, ack_en, 2'b00};
      2'd2:    reg_rdata = status;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng <= E_IDLE; kind <= K_A1; ph <= '0; bitn <= '0; cnt <= '0;
      m_r <= '0; n_r <= '0; data_r <= '0; sh <= '0; status <= ST_NONE;
      iflg <= 1'b0; ack_en <= 1'b0; en <= 1'b0; ie <= 1'b0;
      in_xfer <= 1'b0; after_start <= 1'b0; need_a2 <= 1'b0; rw <= 1'b0;
      tcand <= 1'b0; got_ack <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else if (reg_wr && reg_addr == 2'd3) begin
      eng <= E_IDLE; status <= ST_NONE; iflg <= 1'b0; ack_en <= 1'b0;
      en <= 1'b0; ie <= 1'b0; in_xfer <= 1'b0; after_start <= 1'b0;
      need_a2 <= 1'b0; rw <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 2'd0 && eng == E_IDLE) data_r <= reg_wdata;
      if (reg_wr && reg_addr == 2'd2) begin
        m_r <= reg_wdata[NW+MW-1:NW];
        n_r <= reg_wdata[NW-1:0];
      end
      if (ctrl_wr) begin
        ack_en <= reg_wdata[2];
        en     <= reg_wdata[6];
        ie     <= reg_wdata[7];
        if (!reg_wdata[3]) iflg <= 1'b0;
      end
      if (go_start || go_stop || go_byte) begin
        ph <= '0; bitn <= '0; cnt <= period_m1; status <= ST_NONE;
      end
      if (go_start) eng <= E_START;
      if (go_stop)  eng <= E_STOP;
      if (go_byte) begin
        eng  <= E_BIT;
        kind <= nk;
        sh   <= (nk == K_RD) ? 8'h00 : data_r;
        if (after_start) begin
          rw    <= data_r[0];
          tcand <= data_r[7:3] == 5'b11110;
        end
      end

      if (eng != E_IDLE) begin
        if (!tick) begin
          if (cnt != '0) cnt <= cnt - CW'(1);
        end else begin
          cnt <= period_m1;
          ph  <= ph + 2'd1;
          unique case (eng)
            E_START: unique case (ph)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              default: begin
                scl_oe <= 1'b1; eng <= E_IDLE; iflg <= 1'b1;
                status <= in_xfer ? ST_RSTART : ST_START;
                in_xfer <= 1'b1; after_start <= 1'b1; need_a2 <= 1'b0;
              end
            endcase
            E_STOP: unique case (ph)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              default: begin
                sda_oe <= 1'b0; eng <= E_IDLE; in_xfer <= 1'b0;
                after_start <= 1'b0; need_a2 <= 1'b0;
              end
            endcase
            E_BIT: unique case (ph)
              2'd0: sda_oe <= bitn[3] ? (kind == K_RD && ack_en) : (kind != K_RD && !sh[7]);
              2'd1: scl_oe <= 1'b0;
              2'd2: begin
                if (bitn[3]) got_ack <= !sda_in;
                else if (kind != K_RD && !sda_oe && !sda_in) begin
                  sda_oe <= 1'b0; scl_oe <= 1'b0; eng <= E_IDLE; status <= ST_ARB;
                  iflg <= 1'b1; in_xfer <= 1'b0; after_start <= 1'b0; need_a2 <= 1'b0;
                end else sh <= {sh[6:0], sda_in};
              end
              default: begin
                scl_oe <= 1'b1;
                if (!bitn[3]) bitn <= bitn + 4'd1;
                else begin
                  sda_oe <= 1'b0; eng <= E_IDLE; iflg <= 1'b1; after_start <= 1'b0;
                  unique case (kind)
                    K_A1: begin
                      status  <= rw ? (got_ack ? 8'h40 : 8'h48) : (got_ack ? 8'h18 : 8'h20);
                      need_a2 <= got_ack && tcand;
                    end
                    K_A2: begin
                      status  <= rw ? (got_ack ? 8'hE0 : 8'hE8) : (got_ack ? 8'hD0 : 8'hD8);
                      need_a2 <= 1'b0;
                    end
                    K_WR: status <= got_ack ? 8'h28 : 8'h30;
                    default: begin
                      status <= ack_en ? 8'h50 : 8'h58;
                      data_r <= sh;
                    end
                  endcase
                end
              end
            endcase
            default: eng <= E_IDLE;
          endcase
        end
      end
    end
  end

  a_r2_flag_engine_idle: assert property (@(posedge clk) disable iff (!rst_n)
    iflg |-> eng == E_IDLE);
  a_r11_scl_held: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && in_xfer) |-> scl_oe);
  a_r7_nostatus_noflag: assert property (@(posedge clk) disable iff (!rst_n)
    status == ST_NONE |-> !iflg);
  a_r9_arb_release: assert property (@(posedge clk) disable iff (!rst_n)
    status == ST_ARB |-> (!scl_oe && !sda_oe && !in_xfer));
endmodule

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic s_drive = 1'b0, grab = 1'b0;
  wire scl_bus = !scl_oe;
  wire sda_bus = !(sda_oe || s_drive || grab);

  i2c_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .scl_in(scl_bus), .sda_oe(sda_oe), .sda_in(sda_bus)
  );

  localparam logic [6:0] SLV = 7'h2A;
  localparam logic [7:0] TEN_LO = 8'h55, RD_VAL = 8'h9C;
  localparam logic [7:0] C_GO = 8'hC4, C_START = 8'hE4, C_STOP = 8'hD4, C_NACK = 8'hC0;

  int checks = 0, errors = 0, hi_cnt = 0;
  bit done = 0;

  always @(negedge clk) if (!scl_oe) hi_cnt++;

  // behavioural slave
  logic pscl = 1'b1, psda = 1'b1, scl_now, sda_now, ack;
  logic [7:0] shft = 8'h00, tx_byte = 8'h00, last_wr = 8'h00;
  int cnt = 0, byte_i = 0;
  bit got_rise = 0, tx_mode = 0, go_tx = 0, ten = 0, rw_s = 0, m_ack = 0;
  bit stop_seen = 0, wr_ack_en = 1;

  always @(negedge clk) begin
    scl_now = scl_bus; sda_now = sda_bus;
    if (pscl && scl_now && psda && !sda_now) begin
      cnt = 0; byte_i = 0; tx_mode = 0; go_tx = 0; s_drive = 1'b0; got_rise = 0;
    end else if (pscl && scl_now && !psda && sda_now) begin
      stop_seen = 1; s_drive = 1'b0; tx_mode = 0; got_rise = 0;
    end else if (!pscl && scl_now) begin
      got_rise = 1;
      if (cnt < 8) shft = {shft[6:0], sda_now};
      else m_ack = !sda_now;
    end else if (pscl && !scl_now && got_rise) begin
      if (cnt == 7) begin
        cnt = 8;
        if (tx_mode) s_drive = 1'b0;
        else begin
          if (byte_i == 0) begin
            ten = shft[7:3] == 5'b11110; rw_s = shft[0];
            ack = ten || shft[7:1] == SLV; go_tx = ack && shft[0] && !ten;
          end else if (byte_i == 1 && ten) begin
            ack = shft == TEN_LO; go_tx = ack && rw_s;
          end else begin
            ack = wr_ack_en; last_wr = shft;
          end
          s_drive = ack; byte_i++;
        end
      end else if (cnt == 8) begin
        cnt = 0; s_drive = 1'b0;
        if (tx_mode) begin
          if (m_ack) begin tx_byte = tx_byte + 8'd1; s_drive = !tx_byte[7]; end
          else tx_mode = 0;
        end else if (go_tx) begin
          go_tx = 0; tx_mode = 1; tx_byte = RD_VAL; s_drive = !tx_byte[7];
        end
      end else begin
        cnt++;
        if (tx_mode) s_drive = !tx_byte[7-cnt];
      end
    end
    pscl = scl_now; psda = sda_now;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_flag(input string req);
    logic [7:0] v;
    int n = 0;
    forever begin
      @(negedge clk); rd(2'd1, v);
      if (v[3]) break;
      n++;
      if (n > 6000) begin
        checks++; errors++;
        $display("FAIL %s flag timeout actual=0 expected=1", req);
        break;
      end
    end
  endtask

  task automatic step(input logic [7:0] ctl, input string req, input logic [7:0] exp_st);
    logic [7:0] v;
    wr(2'd1, ctl); wait_flag(req); rd(2'd2, v); chk(req, v, exp_st);
  endtask

  task automatic do_stop(input string req);
    logic [7:0] v;
    stop_seen = 0;
    wr(2'd1, C_STOP); repeat (100) @(negedge clk);
    rd(2'd2, v); chk({req, " status"}, v, 8'hF8);
    rd(2'd1, v); chk({req, " flag"}, v[3], 0);
    chk({req, " lines"}, {scl_oe, sda_oe}, 0);
    chk({req, " stop seen"}, stop_seen, 1);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd2, v); chk("R1 status", v, 8'hF8);
    rd(2'd1, v); chk("R1 flag", v[3], 0);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_write;
    logic [7:0] v;
    int base;
    step(C_START, "R2", 8'h08);
    chk("R10 irq on flag", irq, 1);
    chk("R2 scl held", scl_oe, 1);
    wr(2'd0, {SLV, 1'b0});
    base = hi_cnt;
    step(C_GO, "R3 write addr ack", 8'h18);
    chk("R12 scl high cycles P=4", hi_cnt - base, 72);
    wr(2'd1, 8'hCC); repeat (150) @(negedge clk);
    rd(2'd2, v); chk("R11 status kept", v, 8'h18);
    rd(2'd1, v); chk("R11 flag kept", v[3], 1);
    chk("R11 scl low", scl_oe, 1);
    wr(2'd1, 8'h4C);
    chk("R10 irq masked", irq, 0);
    wr(2'd0, 8'hA5);
    step(C_GO, "R4 data ack", 8'h28);
    chk("R4 slave byte", last_wr, 8'hA5);
    chk("R10 irq", irq, 1);
    wr_ack_en = 0;
    wr(2'd0, 8'h3C);
    step(C_GO, "R4 data nack", 8'h30);
    wr_ack_en = 1;
    do_stop("R7");
  endtask

  task automatic t_read;
    logic [7:0] v;
    step(C_START, "R2", 8'h08);
    wr(2'd0, 8'h22);
    step(C_GO, "R3 write addr nack", 8'h20);
    step(C_START, "R6 repeated start", 8'h10);
    wr(2'd0, {SLV, 1'b1});
    step(C_GO, "R3 read addr ack", 8'h40);
    step(C_GO, "R5 read ack", 8'h50);
    rd(2'd0, v); chk("R5 data 1", v, RD_VAL);
    step(C_NACK, "R5 read nack", 8'h58);
    rd(2'd0, v); chk("R5 data 2", v, RD_VAL + 8'd1);
    do_stop("R7");
  endtask

  task automatic t_ten;
    logic [7:0] v;
    step(C_START, "R2", 8'h08);
    wr(2'd0, 8'hF2); step(C_GO, "R8 addr1 w", 8'h18);
    wr(2'd0, 8'h66); step(C_GO, "R8 addr2 w nack", 8'hD8);
    step(C_START, "R6", 8'h10);
    wr(2'd0, 8'hF2); step(C_GO, "R8 addr1 w", 8'h18);
    wr(2'd0, TEN_LO); step(C_GO, "R8 addr2 w ack", 8'hD0);
    wr(2'd0, 8'h11); step(C_GO, "R8 data after addr2", 8'h28);
    step(C_START, "R6", 8'h10);
    wr(2'd0, 8'hF3); step(C_GO, "R8 addr1 r", 8'h40);
    wr(2'd0, TEN_LO); step(C_GO, "R8 addr2 r ack", 8'hE0);
    step(C_NACK, "R8 read after addr2", 8'h58);
    rd(2'd0, v); chk("R8 read data", v, RD_VAL);
    do_stop("R7");
  endtask

  task automatic t_disabled;
    logic [7:0] v;
    wr(2'd1, 8'hA4); repeat (100) @(negedge clk);
    rd(2'd2, v); chk("R14 no enable status", v, 8'hF8);
    rd(2'd1, v); chk("R14 no enable flag", v[3], 0);
    chk("R14 no enable lines", {scl_oe, sda_oe}, 0);
    wr(2'd1, C_GO); repeat (100) @(negedge clk);
    rd(2'd2, v); chk("R14 byte without start", v, 8'hF8);
    rd(2'd1, v); chk("R14 byte without start flag", v[3], 0);
  endtask

  task automatic t_soft;
    logic [7:0] v;
    step(C_START, "R2", 8'h08);
    wr(2'd0, {SLV, 1'b0}); step(C_GO, "R3", 8'h18);
    wr(2'd3, 8'h00);
    rd(2'd2, v); chk("R13 status", v, 8'hF8);
    rd(2'd1, v); chk("R13 flag", v[3], 0);
    chk("R13 irq", irq, 0);
    chk("R13 lines", {scl_oe, sda_oe}, 0);
    step(C_START, "R13 fresh start", 8'h08);
    do_stop("R7");
  endtask

  task automatic t_arb;
    int base;
    wr(2'd2, 8'h12);
    step(C_START, "R2", 8'h08);
    wr(2'd0, {SLV, 1'b0});
    base = hi_cnt;
    step(C_GO, "R3", 8'h18);
    chk("R12 scl high cycles P=12", hi_cnt - base, 216);
    grab = 1'b1;
    wr(2'd0, 8'hFF);
    step(C_GO, "R9 arbitration lost", 8'h38);
    chk("R9 lines released", {scl_oe, sda_oe}, 0);
    grab = 1'b0;
    repeat (5) @(negedge clk);
    step(C_START, "R9 fresh start", 8'h08);
    do_stop("R7");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    wr(2'd2, 8'h09);
    t_write;
    t_read;
    t_ten;
    t_disabled;
    t_soft;
    t_arb;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule